// File: doc/BRIEF.md
# Power-Management Wake Event Controller

This block supervises a device that has been put into a low-power, wake-waiting state. While armed, it watches nine general-purpose input pins and three network indications: a magic-packet strobe, a strobe for a frame whose destination address equals the station address, and a link-up level from the PHY. When an enabled source fires, it raises a power-management event (PME) towards an external power controller. A sticky flag word records which sources caused the event.

The external controller acknowledges the event by pulling an active-low clear input low. At the cycle the clear goes low, the block samples a mode-select pin to decide its next state. A 1 re-arms wake-waiting mode and a 0 returns the device to normal operation. Each clear assertion also issues a one-cycle request to reload configuration from non-volatile storage. General-purpose pin 5 is reserved for the PME itself and pin 6 for the mode select, so neither can wake the device. The PME output can be a held level or a fixed-length pulse, and it can be driven push-pull or open-drain.

Top module: `pme_wake_ctrl`

## Requirements
- R1: After reset, `wake_mode_o`, `wake_flags_o` and `reload_req_o` are 0. In push-pull mode `pme_o` is 0 and `pme_oe_o` is 1.
- R2: Reset leaves the block in normal mode. In normal mode every wake source is ignored. A one-cycle `sleep_req_i` puts the block into wake-waiting mode (`wake_mode_o`=1) at the next edge.
- R3: Each `gpio_i` bit passes through a two-flop synchronizer, so a pin change reaches the PME on the third rising edge. A pin wakes only when its bit in `cfg_pin_en_i` is set. Bits 5 and 6 of `gpio_i` never wake the block, whatever their enable bits say.
- R4: When `cfg_pme_en_i` is 0, no source raises the PME or alters `wake_flags_o`.
- R5: While armed, a high `magic_pkt_i` or `addr_match_i` raises the PME at the next edge. A rising edge of `link_up_i` does the same, but a link that merely stays high does not.
- R6: With `cfg_pulse_i`=0, the PME stays asserted until the next clear.
- R7: With `cfg_pulse_i`=1, the PME is asserted for exactly 16 cycles. It does not fire again until a clear has been seen.
- R8: In push-pull mode (`cfg_open_drain_i`=0), `pme_oe_o`=1 and `pme_o` equals the event state. In open-drain mode, `pme_o`=0 and `pme_oe_o` is 1 only while the event is asserted.
- R9: On firing, `wake_flags_o` captures the active sources and holds them until a clear. Bits [10:0] hold the pins by index, bit 11 the magic packet, bit 12 the address match and bit 13 the link-up.
- R10: While `clear_n_i` is 0, the PME is deasserted, the flags are zero and no event fires, even if a source is active in the same cycle. On the first low cycle of `clear_n_i`, `gpio_i[6]` is sampled: 1 keeps the block in wake-waiting mode and re-arms it, 0 returns it to normal mode.
- R11: `reload_req_o` is high for exactly one cycle, on the edge after each high-to-low transition of `clear_n_i`.
- R12: In `cfg_pin_pol_i`, a 0 bit makes its pin active low and a 1 bit makes it active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_i | input | 11 | General-purpose pins; bit 6 is the mode select, bit 5 is reserved |
| magic_pkt_i | input | 1 | Magic-packet-received strobe |
| addr_match_i | input | 1 | Destination-address match strobe |
| link_up_i | input | 1 | PHY link-up level |
| sleep_req_i | input | 1 | Enter wake-waiting mode |
| clear_n_i | input | 1 | Active-low event clear from the power controller |
| cfg_pme_en_i | input | 1 | Global PME enable |
| cfg_pulse_i | input | 1 | 1 = pulse output, 0 = level output |
| cfg_open_drain_i | input | 1 | 1 = open-drain driver, 0 = push-pull |
| cfg_pin_en_i | input | 11 | Per-pin wake enables |
| cfg_pin_pol_i | input | 11 | Per-pin polarity (0 = active low) |
| pme_o | output | 1 | PME data output |
| pme_oe_o | output | 1 | PME output enable |
| wake_mode_o | output | 1 | 1 while in wake-waiting mode |
| wake_flags_o | output | 14 | Sticky cause flags |
| reload_req_o | output | 1 | One-cycle configuration reload request |

## Verification
Two things can fall in the same cycle: a wake source firing and the external controller asserting the clear. The bench drives a magic-packet strobe on exactly the cycle that `clear_n_i` first goes low. It then checks that the PME stays low, that no flag is captured, and that the reload request and the mode-select sampling still take effect on the following edge. A second case drives two sources together in one cycle and checks that both flag bits are captured by a single event.

// File: rtl/pme_wake_pkg.sv
package pme_wake_pkg;

    localparam int N_PINS    = 11;
    localparam int PME_PIN   = 5;
    localparam int SEL_PIN   = 6;
    localparam int PULSE_LEN = 16;

    typedef struct packed {
        logic              link;
        logic              addr;
        logic              magic;
        logic [N_PINS-1:0] pins;
    } wake_src_t;

    localparam int SRC_W = $bits(wake_src_t);

    typedef enum logic {
        EV_IDLE  = 1'b0,
        EV_FIRED = 1'b1
    } ev_state_t;

    // Pins usable as wake inputs: everything except the two reserved ones.
    function automatic logic [N_PINS-1:0] wake_pin_mask();
        logic [N_PINS-1:0] m;
        for (int i = 0; i < N_PINS; i++) begin
            m[i] = (i != PME_PIN) && (i != SEL_PIN);
        end
        return m;
    endfunction

    function automatic logic src_any(wake_src_t s);
        return |s;
    endfunction

endpackage

// File: rtl/pme_pin_qual.sv
module pme_pin_qual
    import pme_wake_pkg::*;
#(
    parameter int NP = N_PINS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] pin_i,
    input  logic [NP-1:0] en_i,
    input  logic [NP-1:0] pol_i,
    output logic [NP-1:0] hit_o
);
    localparam logic [N_PINS-1:0] MASK = wake_pin_mask();

    for (genvar g = 0; g < NP; g++) begin : g_pin
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
            end else begin
                s1 <= pin_i[g];
                s2 <= s1;
            end
        end
        // polarity 0: low level is the active one
        assign hit_o[g] = (pol_i[g] ? s2 : ~s2) & en_i[g] & MASK[g];
    end

endmodule

// File: rtl/pme_event_gen.sv
module pme_event_gen
    import pme_wake_pkg::*;
#(
    parameter int PLEN = PULSE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic arm_i,
    input  logic src_any_i,
    input  logic pulse_mode_i,
    input  logic open_drain_i,
    output logic fire_o,
    output logic pme_o,
    output logic pme_oe_o
);
    localparam int CW = $clog2(PLEN + 1);

    ev_state_t      state;
    logic [CW-1:0]  cnt;
    logic           active;

    assign fire_o = arm_i & src_any_i & (state == EV_IDLE) & ~clear_i;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            state <= EV_IDLE;
            cnt   <= '0;
        end else if (fire_o) begin
            state <= EV_FIRED;
            cnt   <= CW'(PLEN);
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign active = (state == EV_FIRED) & (pulse_mode_i ? (cnt != '0) : 1'b1);

    always_comb begin
        if (open_drain_i) begin
            pme_o    = 1'b0;
            pme_oe_o = active;
        end else begin
            pme_o    = active;
            pme_oe_o = 1'b1;
        end
    end

endmodule

// File: rtl/pme_wake_ctrl.sv
module pme_wake_ctrl
    import pme_wake_pkg::*;
#(
    parameter int PLEN = PULSE_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] gpio_i,
    input  logic              magic_pkt_i,
    input  logic              addr_match_i,
    input  logic              link_up_i,
    input  logic              sleep_req_i,
    input  logic              clear_n_i,
    input  logic              cfg_pme_en_i,
    input  logic              cfg_pulse_i,
    input  logic              cfg_open_drain_i,
    input  logic [N_PINS-1:0] cfg_pin_en_i,
    input  logic [N_PINS-1:0] cfg_pin_pol_i,
    output logic              pme_o,
    output logic              pme_oe_o,
    output logic              wake_mode_o,
    output logic [SRC_W-1:0]  wake_flags_o,
    output logic              reload_req_o
);
    logic              clr_prev, clr_fall, link_prev, fire, armed;
    logic [N_PINS-1:0] pin_hit;
    wake_src_t         src, flags;

    pme_pin_qual #(.NP(N_PINS)) u_pins (
        .clk   (clk),
        .rst   (rst),
        .pin_i (gpio_i),
        .en_i  (cfg_pin_en_i),
        .pol_i (cfg_pin_pol_i),
        .hit_o (pin_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_prev  <= 1'b1;
            link_prev <= 1'b0;
        end else begin
            clr_prev  <= clear_n_i;
            link_prev <= link_up_i;
        end
    end

    assign clr_fall = clr_prev & ~clear_n_i;

    always_comb begin
        src.pins  = pin_hit;
        src.magic = magic_pkt_i;
        src.addr  = addr_match_i;
        src.link  = link_up_i & ~link_prev;
    end

    assign armed = wake_mode_o & cfg_pme_en_i;

    pme_event_gen #(.PLEN(PLEN)) u_event (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (~clear_n_i),
        .arm_i        (armed),
        .src_any_i    (src_any(src)),
        .pulse_mode_i (cfg_pulse_i),
        .open_drain_i (cfg_open_drain_i),
        .fire_o       (fire),
        .pme_o        (pme_o),
        .pme_oe_o     (pme_oe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_mode_o  <= 1'b0;
            flags        <= '0;
            reload_req_o <= 1'b0;
        end else begin
            reload_req_o <= clr_fall;
            if (clr_fall) begin
                wake_mode_o <= gpio_i[SEL_PIN];
            end else if (sleep_req_i) begin
                wake_mode_o <= 1'b1;
            end
            if (!clear_n_i) begin
                flags <= '0;
            end else if (fire) begin
                flags <= src;
            end
        end
    end

    assign wake_flags_o = flags;

endmodule

// File: rtl/pme_wake_chk.sv
module pme_wake_chk
    import pme_wake_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clear_n_i,
    input logic             cfg_pme_en_i,
    input logic             cfg_open_drain_i,
    input logic             pme_o,
    input logic             pme_oe_o,
    input logic             wake_mode_o,
    input logic [SRC_W-1:0] wake_flags_o,
    input logic             reload_req_o
);
    // R11
    reload_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clear_n_i) |=> reload_req_o);

    // R11
    reload_single_chk: assert property (@(posedge clk) disable iff (rst)
        reload_req_o |=> !reload_req_o);

    // R10
    clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n_i |=> (wake_flags_o == '0));

    // R10
    clear_pme_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n_i |=> (!pme_o && (!cfg_open_drain_i || !pme_oe_o)));

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_pme_en_i && clear_n_i) |=> $stable(wake_flags_o));

    // R2
    normal_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!wake_mode_o && clear_n_i) |=> $stable(wake_flags_o));

endmodule

bind pme_wake_ctrl pme_wake_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .clear_n_i        (clear_n_i),
    .cfg_pme_en_i     (cfg_pme_en_i),
    .cfg_open_drain_i (cfg_open_drain_i),
    .pme_o            (pme_o),
    .pme_oe_o         (pme_oe_o),
    .wake_mode_o      (wake_mode_o),
    .wake_flags_o     (wake_flags_o),
    .reload_req_o     (reload_req_o)
);

// File: tb/test_pme_wake_ctrl.sv
`timescale 1ns/1ps
module test_pme_wake_ctrl;
    import pme_wake_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [N_PINS-1:0] gpio_i;
    logic              magic_pkt_i, addr_match_i, link_up_i, sleep_req_i, clear_n_i;
    logic              cfg_pme_en_i, cfg_pulse_i, cfg_open_drain_i;
    logic [N_PINS-1:0] cfg_pin_en_i, cfg_pin_pol_i;
    logic              pme_o, pme_oe_o, wake_mode_o, reload_req_o;
    logic [SRC_W-1:0]  wake_flags_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pme_wake_ctrl i_pme_wake_ctrl (
        .clk(clk), .rst(rst), .gpio_i(gpio_i),
        .magic_pkt_i(magic_pkt_i), .addr_match_i(addr_match_i), .link_up_i(link_up_i),
        .sleep_req_i(sleep_req_i), .clear_n_i(clear_n_i),
        .cfg_pme_en_i(cfg_pme_en_i), .cfg_pulse_i(cfg_pulse_i),
        .cfg_open_drain_i(cfg_open_drain_i),
        .cfg_pin_en_i(cfg_pin_en_i), .cfg_pin_pol_i(cfg_pin_pol_i),
        .pme_o(pme_o), .pme_oe_o(pme_oe_o), .wake_mode_o(wake_mode_o),
        .wake_flags_o(wake_flags_o), .reload_req_o(reload_req_o)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // clear handshake: pull clear low with a chosen mode select, then release
    task automatic do_clear(input logic sel, input string req);
        gpio_i[SEL_PIN] = sel;
        clear_n_i = 1'b0;
        tick();
        check({req, " reload pulse"}, reload_req_o, 1);
        check({req, " mode after clear"}, wake_mode_o, sel);
        check({req, " flags cleared"}, wake_flags_o, 0);
        clear_n_i = 1'b1;
        gpio_i[SEL_PIN] = 1'b1;
        tick();
        check({req, " reload one cycle"}, reload_req_o, 0);
    endtask

    task automatic t_reset;
        check("R1 wake_mode", wake_mode_o, 0);
        check("R1 flags", wake_flags_o, 0);
        check("R1 reload", reload_req_o, 0);
        check("R1 pme", pme_o, 0);
        check("R1 oe", pme_oe_o, 1);
    endtask

    task automatic t_normal_ignored;
        magic_pkt_i = 1'b1;
        gpio_i[3] = 1'b0;
        tick();
        magic_pkt_i = 1'b0;
        tick(3);
        check("R2 pme in normal mode", pme_o, 0);
        check("R2 flags in normal mode", wake_flags_o, 0);
        gpio_i[3] = 1'b1;
        tick(3);
        sleep_req_i = 1'b1;
        tick();
        sleep_req_i = 1'b0;
        check("R2 enter wake mode", wake_mode_o, 1);
    endtask

    task automatic t_pin_wake;
        cfg_pin_en_i = 11'h008;
        gpio_i[8] = 1'b0;
        gpio_i[3] = 1'b0;
        tick(2);
        check("R3 sync latency", pme_o, 0);
        tick();
        check("R3 pin wake", pme_o, 1);
        check("R9 pin flag", wake_flags_o, 14'h0008);
        gpio_i[3] = 1'b1;
        gpio_i[8] = 1'b1;
        tick(20);
        check("R6 level held", pme_o, 1);
        do_clear(1'b1, "R10 R11 rearm");
        check("R6 cleared", pme_o, 0);
    endtask

    task automatic t_polarity;
        cfg_pin_en_i = 11'h200;
        cfg_pin_pol_i = 11'h200;
        tick(3);
        check("R12 active-high pin", pme_o, 1);
        check("R12 flag bit9", wake_flags_o, 14'h0200);
        cfg_pin_pol_i = '0;
        do_clear(1'b1, "R10 polarity clear");
        tick(3);
        check("R12 idle high ignored", pme_o, 0);
    endtask

    task automatic t_reserved;
        cfg_pin_en_i = '1;
        gpio_i[PME_PIN] = 1'b0;
        gpio_i[SEL_PIN] = 1'b0;
        tick(5);
        check("R3 reserved pins no wake", pme_o, 0);
        check("R3 reserved flags", wake_flags_o, 0);
        gpio_i[PME_PIN] = 1'b1;
        gpio_i[SEL_PIN] = 1'b1;
        tick(3);
    endtask

    task automatic t_global_en;
        cfg_pme_en_i = 1'b0;
        magic_pkt_i = 1'b1;
        tick();
        magic_pkt_i = 1'b0;
        tick(2);
        check("R4 disabled pme", pme_o, 0);
        check("R4 disabled flags", wake_flags_o, 0);
        cfg_pme_en_i = 1'b1;
    endtask

    task automatic t_sources;
        addr_match_i = 1'b1;
        tick();
        addr_match_i = 1'b0;
        check("R5 addr match", pme_o, 1);
        check("R9 addr flag", wake_flags_o, 14'h1000);
        do_clear(1'b1, "R10 addr clear");
        link_up_i = 1'b1;
        tick();
        check("R5 link rise", pme_o, 1);
        check("R9 link flag", wake_flags_o, 14'h2000);
        do_clear(1'b1, "R10 link clear");
        tick(3);
        check("R5 link steady no wake", pme_o, 0);
        link_up_i = 1'b0;
        magic_pkt_i = 1'b1;
        addr_match_i = 1'b1;
        tick();
        magic_pkt_i = 1'b0;
        addr_match_i = 1'b0;
        check("R9 two sources", wake_flags_o, 14'h1800);
        do_clear(1'b1, "R10 dual clear");
    endtask

    task automatic t_pulse;
        cfg_pulse_i = 1'b1;
        magic_pkt_i = 1'b1;
        tick();
        magic_pkt_i = 1'b0;
        check("R7 pulse start", pme_o, 1);
        tick(15);
        check("R7 pulse 16th cycle", pme_o, 1);
        tick();
        check("R7 pulse end", pme_o, 0);
        magic_pkt_i = 1'b1;
        tick();
        magic_pkt_i = 1'b0;
        tick(2);
        check("R7 no refire", pme_o, 0);
        check("R7 flags kept", wake_flags_o, 14'h0800);
        do_clear(1'b1, "R10 pulse clear");
        cfg_pulse_i = 1'b0;
    endtask

    task automatic t_open_drain;
        cfg_open_drain_i = 1'b1;
        tick();
        check("R8 od idle oe", pme_oe_o, 0);
        magic_pkt_i = 1'b1;
        tick();
        magic_pkt_i = 1'b0;
        check("R8 od active oe", pme_oe_o, 1);
        check("R8 od data", pme_o, 0);
        do_clear(1'b1, "R10 od clear");
        check("R8 od released", pme_oe_o, 0);
        cfg_open_drain_i = 1'b0;
    endtask

    task automatic t_clear_race;
        gpio_i[SEL_PIN] = 1'b1;
        clear_n_i = 1'b0;
        magic_pkt_i = 1'b1;
        tick();
        magic_pkt_i = 1'b0;
        check("R10 race pme", pme_o, 0);
        check("R10 race flags", wake_flags_o, 0);
        check("R11 race reload", reload_req_o, 1);
        clear_n_i = 1'b1;
        tick();
        check("R10 race still idle", pme_o, 0);
    endtask

    task automatic t_exit;
        do_clear(1'b0, "R10 exit");
        magic_pkt_i = 1'b1;
        tick();
        magic_pkt_i = 1'b0;
        check("R10 normal after exit", pme_o, 0);
    endtask

    initial begin
        rst = 1'b1;
        gpio_i = '1;
        magic_pkt_i = 1'b0; addr_match_i = 1'b0; link_up_i = 1'b0;
        sleep_req_i = 1'b0; clear_n_i = 1'b1;
        cfg_pme_en_i = 1'b1; cfg_pulse_i = 1'b0; cfg_open_drain_i = 1'b0;
        cfg_pin_en_i = '1; cfg_pin_pol_i = '0;
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_normal_ignored();
        t_pin_wake();
        t_polarity();
        t_reserved();
        t_global_en();
        t_sources();
        t_pulse();
        t_open_drain();
        t_clear_race();
        t_exit();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule